// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the falling edges of a reference pulse stream with the falling edges of a delayed feedback stream. It drives a three-level result made of a data bit and an output-enable bit. When the reference edge comes first, the output drives high until the feedback edge arrives. When the feedback edge comes first, the output drives low. The pulse width therefore follows the phase error, and the filtered output is linear in phase across a full period. Coincident edges give no pulse.

A separate fine comparator covers small feedback-lead errors. To leave that region to it, the detector keeps its output at high impedance while the feedback lead has lasted no more than a programmable number of clock cycles. It drives low only for the part of the lead that goes beyond this window, so it steers the loop only during coarse acquisition.

Both inputs are asynchronous. Each passes through a synchronizer before its falling edge is detected. If a stream delivers two edges before the other stream delivers one, the detector stays in its lead state. This gives frequency as well as phase detection.

Top module: `tri_pfd`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the output is at high impedance: oe=0 and data=0.
- R2: If the reference input falls d>0 cycles before the feedback input, the output drives high (oe=1, data=1) for exactly d clock cycles. The pulse becomes visible after the third rising clock edge that follows the reference fall.
- R3: If the feedback input falls d cycles before the reference input and the window is W, the output drives low (oe=1, data=0) for max(0, d-W) cycles. The low pulse starts W cycles after the detector enters the feedback-lead state.
- R4: A feedback lead of d<=W cycles produces no drive at all: the output stays at oe=0 throughout.
- R5: Falling edges of both inputs detected in the same cycle from the idle state produce no pulse, and the detector remains idle.
- R6: The output never switches directly from driving high to driving low, or from low to high. At least one high-impedance cycle lies between pulses of opposite polarity.
- R7: A second reference fall that arrives before any feedback fall keeps the detector in the reference-lead state. The high pulse then lasts until the feedback fall, measured from the first reference fall.
- R8: Rising transitions on either input have no effect, and the output stays at high impedance.
- R9: Whenever oe=0, data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse stream, compared on falling edges |
| fb_in | input | 1 | Delayed feedback pulse stream, compared on falling edges |
| fine_win | input | WIN_W | Fine-range window length in clock cycles |
| pd_data | output | 1 | Drive level: 1 high, 0 low |
| pd_oe | output | 1 | Output enable: 0 means high impedance |

## Verification
The hardest case to reach from the ports is a feedback lead that ends exactly at the window boundary. A lead of W cycles must give no pulse, and a lead of W+1 cycles must give a single low cycle. The stimulus table places the reference fall at W and at W+1 cycles after the feedback fall, for more than one window setting. Frequency-detection behaviour is reached by repeating the reference fall before the feedback fall.

// File: rtl/tri_pfd_pkg.sv
package tri_pfd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_FB_LEAD  = 2'd1,
        PH_REF_LEAD = 2'd2
    } phase_e;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    localparam int LAST = STAGES;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign fall = chain_q[LAST] & ~chain_q[LAST-1];

endmodule

// File: rtl/pfd_lead_timer.sv
module pfd_lead_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] win,
    output logic          past_win
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign past_win = (cnt_q >= win);

endmodule

// File: rtl/tri_pfd.sv
module tri_pfd
    import tri_pfd_pkg::*;
#(
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [WIN_W-1:0] fine_win,
    output logic             pd_data,
    output logic             pd_oe
);

    localparam int N_IN = 2;

    typedef struct packed {
        phase_e phase;
    } det_state_t;

    det_state_t st_d;
    det_state_t st_q;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] fall_v;
    logic            ref_fall;
    logic            fb_fall;
    logic            past_win;
    logic            in_idle;
    logic            in_ref_lead;
    logic            in_fb_lead;

    assign raw_in = {fb_in, ref_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        pfd_edge_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[gi]),
            .fall (fall_v[gi])
        );
    end

    assign ref_fall = fall_v[0];
    assign fb_fall  = fall_v[1];

    assign in_idle     = (st_q.phase == PH_IDLE);
    assign in_ref_lead = (st_q.phase == PH_REF_LEAD);
    assign in_fb_lead  = (st_q.phase == PH_FB_LEAD);

    pfd_lead_timer #(
        .CW(WIN_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_fb_lead),
        .win     (fine_win),
        .past_win(past_win)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (ref_fall && !fb_fall) begin
                    st_d.phase = PH_REF_LEAD;
                end else if (fb_fall && !ref_fall) begin
                    st_d.phase = PH_FB_LEAD;
                end
            end
            PH_REF_LEAD: begin
                if (fb_fall) begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_FB_LEAD: begin
                if (ref_fall) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pd_oe   = 1'b0;
        pd_data = 1'b0;
        if (in_ref_lead) begin
            pd_oe   = 1'b1;
            pd_data = 1'b1;
        end else if (in_fb_lead && past_win) begin
            pd_oe   = 1'b1;
            pd_data = 1'b0;
        end
    end

endmodule

// File: rtl/tri_pfd_chk.sv
module tri_pfd_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_fall,
    input logic fb_fall,
    input logic in_idle,
    input logic in_ref_lead,
    input logic pd_oe,
    input logic pd_data
);

    p_release_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pd_oe);

    p_coincident_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && ref_fall && fb_fall) |=> (!pd_oe && in_idle));

    p_no_hi_to_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_oe && pd_data) |=> !(pd_oe && !pd_data));

    p_no_lo_to_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_oe && !pd_data) |=> !(pd_oe && pd_data));

    p_repeat_ref_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ref_lead && ref_fall && !fb_fall) |=> (pd_oe && pd_data));

    p_hiz_data_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_oe |-> !pd_data);

endmodule

bind tri_pfd tri_pfd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_fall   (ref_fall),
    .fb_fall    (fb_fall),
    .in_idle    (in_idle),
    .in_ref_lead(in_ref_lead),
    .pd_oe      (pd_oe),
    .pd_data    (pd_data)
);

// File: tb/tri_pfd_tb_top.sv
`timescale 1ns/1ps
module tri_pfd_tb_top;

    localparam int WIN_W = 8;
    localparam int N_VEC = 15;
    // columns: offset (positive: reference leads), window, expected high cycles, expected low cycles
    localparam int OFS [N_VEC] = '{0, 1, 5, 20, 10, -1, -3, -4, -5, -12, -20, -20, -7, -8, -15};
    localparam int WIN [N_VEC] = '{4, 0, 4, 4, 9, 0, 4, 4, 4, 4, 4, 0, 7, 7, 7};
    localparam int EHI [N_VEC] = '{0, 1, 5, 20, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int ELO [N_VEC] = '{0, 0, 0, 0, 0, 1, 0, 0, 1, 8, 16, 20, 0, 1, 8};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b1;
    logic             fb_in = 1'b1;
    logic [WIN_W-1:0] fine_win = '0;
    logic             pd_data;
    logic             pd_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tri_pfd #(.WIN_W(WIN_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .fine_win(fine_win), .pd_data(pd_data), .pd_oe(pd_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    // One phase comparison: leader falls at step 2, trailer |ofs| steps later.
    task automatic run_case(input int ofs, input int win, input int ehi, input int elo, input string tag);
        int d = (ofs < 0) ? -ofs : ofs;
        int hi = 0;
        int lo = 0;
        int bad9 = 0;
        int first = -1;
        int n_steps = d + 16;
        fine_win = WIN_W'(win);
        for (int c = 0; c < n_steps; c++) begin
            @(negedge clk);
            if (pd_oe && pd_data) hi++;
            if (pd_oe && !pd_data) lo++;
            if (!pd_oe && pd_data) bad9++;
            if (pd_oe && first < 0) first = c;
            if (c == 2) begin
                if (ofs >= 0) ref_in = 1'b0;
                if (ofs <= 0) fb_in = 1'b0;
            end
            if (c == 2 + d) begin
                ref_in = 1'b0;
                fb_in = 1'b0;
            end
            if (c == 6 + d) begin
                ref_in = 1'b1;
                fb_in = 1'b1;
            end
        end
        check({tag, " high width"}, hi, ehi);
        check({tag, " low width"}, lo, elo);
        check("R9 data low when released", bad9, 0);
        if (ehi > 0) check("R2 high pulse start step", first, 5);
        if (elo > 0) check("R3 low pulse start step", first, 5 + win);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 oe in reset", int'(pd_oe), 0);
        check("R1 data in reset", int'(pd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after release", int'(pd_oe), 0);
        repeat (4) @(negedge clk);

        // Table sweep over phase offsets (R2 reference lead, R3/R4 feedback lead, R5 coincident)
        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            if (OFS[i] > 0) tag = "R2";
            else if (OFS[i] == 0) tag = "R5";
            else if (ELO[i] == 0) tag = "R4";
            else tag = "R3";
            run_case(OFS[i], WIN[i], EHI[i], ELO[i], tag);
        end

        // R7: reference falls twice before feedback; high lasts from first reference fall
        begin
            int hi = 0;
            int lo = 0;
            fine_win = 8'd2;
            for (int c = 0; c < 28; c++) begin
                @(negedge clk);
                if (pd_oe && pd_data) hi++;
                if (pd_oe && !pd_data) lo++;
                if (c == 2) ref_in = 1'b0;
                if (c == 5) ref_in = 1'b1;
                if (c == 8) ref_in = 1'b0;
                if (c == 12) fb_in = 1'b0;
                if (c == 16) begin ref_in = 1'b1; fb_in = 1'b1; end
            end
            check("R7 repeated reference high width", hi, 10);
            check("R7 repeated reference no low", lo, 0);
        end

        // R8: rising edges alone give no drive (coincident fall first, R5)
        begin
            int drv = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (pd_oe) drv++;
                if (c == 1) begin ref_in = 1'b0; fb_in = 1'b0; end
                if (c == 10) ref_in = 1'b1;
                if (c == 20) fb_in = 1'b1;
            end
            check("R8 rising edges ignored", drv, 0);
        end

        // R1: reset in the middle of a high pulse releases at once and stays idle
        begin
            int drv = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (c == 1) ref_in = 1'b0;
            end
            check("R2 driving before mid-pulse reset", int'(pd_oe && pd_data), 1);
            rst_n = 1'b0;
            #1;
            check("R1 oe during mid-pulse reset", int'(pd_oe), 0);
            ref_in = 1'b1;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (pd_oe) drv++;
            end
            check("R1 idle after mid-pulse reset", drv, 0);
        end

        finish_run();
    end

endmodule